// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device-side engine that stores incoming Ethernet frames into memory buffers described by a ring of descriptors. Frames arrive one byte per beat, with flags marking the first beat, the last beat and any beat received in error. For each frame the engine takes the descriptor it currently points at. It writes the frame bytes one after another from that descriptor's buffer pointer onward, then rewrites the descriptor's status word to hand the entry back to the host, and then follows the descriptor's link word to the next entry.

The descriptors live in a small word-addressed store inside the block. The host reaches that store through a simple read/write port. It builds the ring there and sets each free entry's status word to the buffer capacity with the ownership bit clear. It loads the ring base, then pulses a receive-enable input. To recycle an entry, the host clears its status word back to the capacity and pulses enable again. If a frame begins on an entry the host has not yet returned, the frame is dropped and counted, and the engine stops until the next enable pulse.

Each descriptor occupies four consecutive 32-bit words. Frame bytes leave the block on a byte write port carrying an address, so the buffer memory itself sits outside.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the missed-frame count is 0, no buffer write is made, the descriptor pointer is 0 and the engine is stopped, so a frame arriving before the first enable pulse is neither stored nor counted.
- R2: A descriptor at byte address P has these words: the link word at P, the status word at P+4, the buffer pointer at P+8, and a software word at P+12 that the engine never writes. The host port writes the word selected by host_addr bits 6:2 at the clock edge when host_we is high. host_rdata returns the selected word in the same cycle.
- R3: A pulse on ring_base_load loads the descriptor pointer when no frame is in progress. A pulse on rx_enable starts a stopped engine. A frame begins only on a valid beat that carries rx_sof.
- R4: Byte k (counting from 0) of a stored frame raises buf_we, with buf_addr equal to the buffer pointer plus k and buf_data equal to the byte, in the cycle the beat is presented.
- R5: At the edge that ends the beat carrying rx_eof, the status word of the entry is rewritten. Bit 31 (ownership) is set, bit 30 (continuation) is clear, and bits 11:0 hold the number of bytes stored, which counts every delivered byte including the trailing 4 CRC bytes.
- R6: In the completed status, bit 27 (good frame) is set only when no beat of the frame carried rx_err and the frame fitted. Bit 22 (too long) is set when the frame had more bytes than the capacity found in bits 11:0 of the status word at the frame's first beat.
- R7: Bytes past the capacity are not written, and the size field of a too-long frame equals the capacity.
- R8: After a frame completes, the pointer takes the value of the completed entry's link word, so the ring order follows the links. A first beat in the very next cycle is stored in the linked entry.
- R9: When a first beat arrives while the current entry has bit 31 set, nothing is written, that entry is left unchanged, the missed count rises by 1, the pointer stays, and the engine stops. Later frames are then neither stored nor counted until an rx_enable pulse.
- R10: When the engine's status write-back and a host write fall in the same cycle, both take effect if they target different words. If they target the same word, the engine's status value is kept.
- R11: Beats with rx_valid low, and beats without rx_sof while the engine waits for a frame, write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive beat present |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First beat of a frame |
| rx_eof | input | 1 | Last beat of a frame |
| rx_err | input | 1 | Beat received with an error |
| rx_enable | input | 1 | Pulse that starts a stopped engine |
| ring_base_load | input | 1 | Pulse that loads the descriptor pointer |
| ring_base | input | 32 | Byte address of the first descriptor |
| host_we | input | 1 | Host write to the descriptor store |
| host_addr | input | 32 | Host byte address into the descriptor store |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Descriptor word at host_addr |
| buf_we | output | 1 | Frame byte write strobe |
| buf_addr | output | 32 | Byte address of the frame byte |
| buf_data | output | 8 | Frame byte |
| missed_cnt | output | 16 | Saturating count of frames dropped on a host-owned entry |

## Verification
The engine's status write-back on a frame's last beat and a host write to the descriptor store can land on the same clock edge. Both write into the same store, so the store needs a rule for which one takes effect. The bench provokes this twice. First it drives a host write to another entry's status word in the cycle of a last beat, and it judges the result by reading back both words: each must hold its own writer's value. Then it aims the host write at the very status word being completed, and it expects the engine's completion value to be the one read back.

// File: rtl/rxr_pkg.sv
// Shared constants and types for the receive ring writer.
// Status-word bit positions are fixed because host software decodes them.
package rxr_pkg;

    localparam int WORD_W   = 32;  // descriptor word and address width
    localparam int SIZE_W   = 12;  // size field in status bits 11:0
    localparam int OWN_BIT  = 31;  // set: entry holds a frame for the host
    localparam int MORE_BIT = 30;  // frame continued in another buffer
    localparam int OK_BIT   = 27;  // frame received without fault
    localparam int LONG_BIT = 22;  // frame exceeded buffer capacity

    // Word offsets inside one descriptor
    localparam int LINK_OFS = 0;
    localparam int STAT_OFS = 1;
    localparam int BUF_OFS  = 2;

    typedef enum logic [1:0] {
        FILL_OFF   = 2'd0,
        FILL_READY = 2'd1,
        FILL_RECV  = 2'd2
    } fill_state_e;

    // Builds the completion status word from byte count and fault flags.
    function automatic logic [WORD_W-1:0] make_status(
        input logic [SIZE_W-1:0] nbytes,
        input logic              faulty,
        input logic              too_long
    );
        logic [WORD_W-1:0] s;
        s                = '0;
        s[OWN_BIT]       = 1'b1;
        s[MORE_BIT]      = 1'b0;
        s[OK_BIT]        = !faulty && !too_long;
        s[LONG_BIT]      = too_long;
        s[SIZE_W-1:0]    = nbytes;
        return s;
    endfunction

endpackage

// File: rtl/rxr_desc_store.sv
// Word-addressed descriptor store.
// Serves the host read/write port and exposes the link, status and buffer
// words of the descriptor at cur_ptr. Assumes word-aligned addresses; the
// address wraps modulo DESC_WORDS. The engine write-back wins over a host
// write to the same word in the same cycle.
module rxr_desc_store
    import rxr_pkg::*;
#(
    parameter int DESC_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cur_ptr,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              wb_en,
    input  logic [WORD_W-1:0] wb_status,
    output logic [WORD_W-1:0] cur_link,
    output logic [WORD_W-1:0] cur_status,
    output logic [WORD_W-1:0] cur_bufptr
);

    localparam int IDX_W = $clog2(DESC_WORDS);

    logic [WORD_W-1:0] words [DESC_WORDS];
    logic [IDX_W-1:0]  host_idx;
    logic [IDX_W-1:0]  base_idx;
    logic [IDX_W-1:0]  stat_idx;
    logic [IDX_W-1:0]  link_idx;
    logic [IDX_W-1:0]  buf_idx;
    logic              unused_addr_bits;

    // Word indices for host access and for the current descriptor
    assign host_idx = host_addr[IDX_W+1:2];
    assign base_idx = cur_ptr[IDX_W+1:2];
    assign link_idx = base_idx + IDX_W'(LINK_OFS);
    assign stat_idx = base_idx + IDX_W'(STAT_OFS);
    assign buf_idx  = base_idx + IDX_W'(BUF_OFS);

    assign unused_addr_bits = ^{host_addr[1:0], host_addr[WORD_W-1:IDX_W+2],
                                cur_ptr[1:0], cur_ptr[WORD_W-1:IDX_W+2]};

    generate
        for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(w);
            logic [WORD_W-1:0] word_q;

            // One storage word: engine write-back first, then host write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wb_en && (stat_idx == MY_IDX)) begin
                    word_q <= wb_status;
                end else if (host_we && (host_idx == MY_IDX)) begin
                    word_q <= host_wdata;
                end
            end

            assign words[w] = word_q;
        end
    endgenerate

    // Combinational read ports
    assign host_rdata = words[host_idx];
    assign cur_link   = words[link_idx];
    assign cur_status = words[stat_idx];
    assign cur_bufptr = words[buf_idx];

endmodule

// File: rtl/rxr_cursor.sv
// Current-descriptor pointer.
// Loads the ring base on request (when allowed) and follows the link word
// of each completed entry. Pointers are forced to word alignment.
module rxr_cursor
    import rxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              load_ok,
    input  logic [WORD_W-1:0] base,
    input  logic              adv,
    input  logic [WORD_W-1:0] link,
    output logic [WORD_W-1:0] cur_ptr
);

    logic unused_low_bits;
    assign unused_low_bits = ^{base[1:0], link[1:0]};

    // Pointer update: advancing along the link has priority over a base load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr <= '0;
        end else if (adv) begin
            cur_ptr <= {link[WORD_W-1:2], 2'b00};
        end else if (load_req && load_ok) begin
            cur_ptr <= {base[WORD_W-1:2], 2'b00};
        end
    end

endmodule

// File: rtl/rxr_fill_ctrl.sv
// Frame fill controller.
// Takes a byte stream with first/last/error flags and writes each stored
// byte to the current buffer. On the last beat it produces the completion
// status and an advance request. A first beat on a host-owned entry is
// dropped, reported as a miss, and stops the engine until rx_enable.
// Assumes cur_status/cur_bufptr describe the current entry combinationally.
module rxr_fill_ctrl
    import rxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    input  logic              rx_enable,
    input  logic [WORD_W-1:0] cur_status,
    input  logic [WORD_W-1:0] cur_bufptr,
    output logic              buf_we,
    output logic [WORD_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic              wb_en,
    output logic [WORD_W-1:0] wb_status,
    output logic              adv,
    output logic              miss,
    output logic              load_ok,
    output logic              armed,
    output logic              busy
);

    fill_state_e       state_q;
    logic [SIZE_W-1:0] cap_q, cnt_q;
    logic [WORD_W-1:0] bptr_q;
    logic              err_q, long_q;

    logic              starting, entry_owned, take, fits, done;
    logic [SIZE_W-1:0] eff_cap, eff_cnt, new_cnt;
    logic [WORD_W-1:0] eff_bptr;
    logic              eff_err, eff_long, new_err, new_long;
    logic              unused_status_bits;

    assign unused_status_bits = ^cur_status[WORD_W-2:SIZE_W];

    // Beat decode and per-frame context selection
    always_comb begin
        starting    = (state_q == FILL_READY) && rx_valid && rx_sof;
        entry_owned = cur_status[OWN_BIT];
        take        = (starting && !entry_owned) ||
                      ((state_q == FILL_RECV) && rx_valid);
        if (state_q == FILL_RECV) begin
            eff_bptr = bptr_q;
            eff_cap  = cap_q;
            eff_cnt  = cnt_q;
            eff_err  = err_q;
            eff_long = long_q;
        end else begin
            eff_bptr = cur_bufptr;
            eff_cap  = cur_status[SIZE_W-1:0];
            eff_cnt  = '0;
            eff_err  = 1'b0;
            eff_long = 1'b0;
        end
        fits     = eff_cnt < eff_cap;
        new_cnt  = eff_cnt + SIZE_W'(fits);
        new_err  = eff_err | rx_err;
        new_long = eff_long | !fits;
        done     = take && rx_eof;
    end

    // Outputs toward buffer, store, cursor and miss counter
    assign buf_we    = take && fits;
    assign buf_addr  = eff_bptr + {{(WORD_W-SIZE_W){1'b0}}, eff_cnt};
    assign buf_data  = rx_data;
    assign wb_en     = done;
    assign wb_status = make_status(new_cnt, new_err, new_long);
    assign adv       = done;
    assign miss      = starting && entry_owned;
    assign load_ok   = (state_q != FILL_RECV);
    assign armed     = (state_q == FILL_READY);
    assign busy      = (state_q == FILL_RECV);

    // State and per-frame context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_OFF;
            cap_q   <= '0;
            cnt_q   <= '0;
            bptr_q  <= '0;
            err_q   <= 1'b0;
            long_q  <= 1'b0;
        end else begin
            if (take) begin
                bptr_q <= eff_bptr;
                cap_q  <= eff_cap;
                cnt_q  <= new_cnt;
                err_q  <= new_err;
                long_q <= new_long;
            end
            case (state_q)
                FILL_OFF: begin
                    if (rx_enable) state_q <= FILL_READY;
                end
                FILL_READY: begin
                    if (miss)                  state_q <= FILL_OFF;
                    else if (take && !rx_eof)  state_q <= FILL_RECV;
                end
                FILL_RECV: begin
                    if (done) state_q <= FILL_READY;
                end
                default: state_q <= FILL_OFF;
            endcase
        end
    end

endmodule

// File: rtl/rxr_miss_counter.sv
// Saturating counter of frames dropped on a host-owned entry.
module rxr_miss_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    // Count up on each miss, holding at the maximum value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != {CNT_W{1'b1}})) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rxr_ring_writer.sv
// Receive descriptor ring writer, top level.
// Connects the descriptor store, current-descriptor cursor, fill
// controller and miss counter. Assumes the host builds the ring through
// the host port and loads the base before pulsing rx_enable.
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int DESC_WORDS = 32,
    parameter int MISS_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    input  logic              rx_enable,
    input  logic              ring_base_load,
    input  logic [WORD_W-1:0] ring_base,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              buf_we,
    output logic [WORD_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic [MISS_W-1:0] missed_cnt
);

    logic [WORD_W-1:0] cur_ptr, cur_link, cur_status, cur_bufptr;
    logic [WORD_W-1:0] wb_status;
    logic              wb_en, adv, miss, load_ok, armed, busy;

    rxr_desc_store #(
        .DESC_WORDS(DESC_WORDS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_ptr    (cur_ptr),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .wb_en      (wb_en),
        .wb_status  (wb_status),
        .cur_link   (cur_link),
        .cur_status (cur_status),
        .cur_bufptr (cur_bufptr)
    );

    rxr_cursor u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (ring_base_load),
        .load_ok  (load_ok),
        .base     (ring_base),
        .adv      (adv),
        .link     (cur_link),
        .cur_ptr  (cur_ptr)
    );

    rxr_fill_ctrl u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_err     (rx_err),
        .rx_enable  (rx_enable),
        .cur_status (cur_status),
        .cur_bufptr (cur_bufptr),
        .buf_we     (buf_we),
        .buf_addr   (buf_addr),
        .buf_data   (buf_data),
        .wb_en      (wb_en),
        .wb_status  (wb_status),
        .adv        (adv),
        .miss       (miss),
        .load_ok    (load_ok),
        .armed      (armed),
        .busy       (busy)
    );

    rxr_miss_counter #(
        .CNT_W(MISS_W)
    ) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (miss),
        .count (missed_cnt)
    );

endmodule

// File: rtl/rxr_ring_writer_chk.sv
// Assertion checker for rxr_ring_writer, attached by bind.
// Relates engine state, buffer writes, write-back and cursor over time.
module rxr_ring_writer_chk #(
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_we,
    input logic [31:0]       buf_addr,
    input logic [MISS_W-1:0] missed_cnt,
    input logic              armed,
    input logic              busy,
    input logic              wb_en,
    input logic [31:0]       wb_status,
    input logic [31:0]       cur_ptr,
    input logic [31:0]       cur_link
);

    // R1: reset leaves the engine stopped with a zero miss count
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (missed_cnt == '0 && !armed && !busy));

    // R3: a stopped engine neither writes bytes nor completes entries
    p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !busy) |-> (!buf_we && !wb_en));

    // R4: consecutive stored bytes of a frame land at consecutive addresses
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && buf_we && $past(buf_we)) |-> (buf_addr == $past(buf_addr) + 32'd1));

    // R5: completion returns the engine to waiting for the next frame
    p_done_rearms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (armed && !busy));

    // R6: a too-long frame is never marked good
    p_long_not_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_status[22]) |-> !wb_status[27]);

    // R8: after completion the pointer equals the completed entry's link
    p_follow_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (cur_ptr == {$past(cur_link[31:2]), 2'b00}));

    // R9: the miss count only ever steps by one
    p_miss_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == $past(missed_cnt) + 1'b1));

    // R9: a counted miss stops the engine
    p_miss_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_cnt != $past(missed_cnt)) |-> (!armed && !busy));

endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(
    .MISS_W(MISS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_we     (buf_we),
    .buf_addr   (buf_addr),
    .missed_cnt (missed_cnt),
    .armed      (armed),
    .busy       (busy),
    .wb_en      (wb_en),
    .wb_status  (wb_status),
    .cur_ptr    (cur_ptr),
    .cur_link   (cur_link)
);

// File: tb/rxr_ring_writer_tb_top.sv
// Directed testbench for rxr_ring_writer: one task per scenario.
module rxr_ring_writer_tb_top;

    localparam int CLK_P = 10;

    // Ring layout used by the bench: entries at 0x40, 0x50, 0x60, 0x70,
    // linked 0x40 -> 0x60 -> 0x50 -> 0x70 -> 0x40.
    localparam logic [31:0] E0 = 32'h40, E1 = 32'h50, E2 = 32'h60, E3 = 32'h70;
    localparam logic [31:0] B0 = 32'h1000, B1 = 32'h2000, B2 = 32'h3000, B3 = 32'h4000;
    localparam logic [31:0] CAP = 32'h600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic        rx_enable = 1'b0;
    logic        ring_base_load = 1'b0;
    logic [31:0] ring_base = '0;
    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0, host_wdata = '0;
    logic [31:0] host_rdata;
    logic        buf_we;
    logic [31:0] buf_addr;
    logic [7:0]  buf_data;
    logic [15:0] missed_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rxr_ring_writer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_valid       (rx_valid),
        .rx_data        (rx_data),
        .rx_sof         (rx_sof),
        .rx_eof         (rx_eof),
        .rx_err         (rx_err),
        .rx_enable      (rx_enable),
        .ring_base_load (ring_base_load),
        .ring_base      (ring_base),
        .host_we        (host_we),
        .host_addr      (host_addr),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .buf_we         (buf_we),
        .buf_addr       (buf_addr),
        .buf_data       (buf_data),
        .missed_cnt     (missed_cnt)
    );

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        #1 host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [31:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic pulse_enable();
        @(negedge clk); rx_enable = 1'b1;
        @(negedge clk); rx_enable = 1'b0;
    endtask

    task automatic idle_rx();
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    endtask

    // Drives one frame and checks the buffer port on every beat.
    task automatic send_frame(input string tag, input logic [31:0] bptr,
                              input int len, input int cap, input int err_beat,
                              input bit gaps, input bit store, input bit coll,
                              input logic [31:0] caddr, input logic [31:0] cdata,
                              input bit tail_idle);
        int bad = 0;
        for (int k = 0; k < len; k++) begin
            if (gaps && k > 0) begin
                @(negedge clk);
                idle_rx();
                #(CLK_P/4);
                if (buf_we !== 1'b0) bad++;   // R11: invalid beat writes nothing
            end
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(k + 8'h31);
            rx_sof = (k == 0); rx_eof = (k == len - 1); rx_err = (k == err_beat);
            if (coll && k == len - 1) begin
                host_we = 1'b1; host_addr = caddr; host_wdata = cdata;
            end
            #(CLK_P/4);
            begin
                bit exp_we = store && (k < cap);
                if (buf_we !== exp_we) bad++;
                else if (exp_we && (buf_addr !== bptr + 32'(k) || buf_data !== 8'(k + 8'h31))) bad++;
            end
        end
        if (tail_idle || coll) begin
            @(negedge clk);
            idle_rx();
            host_we = 1'b0;
        end
        check(bad == 0, tag, 32'(bad), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #(CLK_P/4);
        check(missed_cnt == 16'd0, "R1 missed count after reset", 32'(missed_cnt), 32'd0);
        check(buf_we == 1'b0, "R1 no buffer write after reset", 32'(buf_we), 32'd0);
        // Entry at pointer 0 is free; engine still stopped, so nothing stored
        send_frame("R1 frame before enable not stored", 32'h0, 6, 0, -1, 1'b0, 1'b0,
                   1'b0, '0, '0, 1'b1);
        #(CLK_P/4);
        check(missed_cnt == 16'd0, "R1 frame before enable not counted", 32'(missed_cnt), 32'd0);
        host_rd(32'h4, v);
        check(v == 32'h0, "R1 status at pointer 0 untouched", v, 32'h0);
    endtask

    task automatic t_setup();
        logic [31:0] v;
        host_wr(E0, E2); host_wr(E0 + 4, CAP);     host_wr(E0 + 8, B0);
        host_wr(E0 + 12, 32'hA5A5_0F0F);
        host_wr(E2, E1); host_wr(E2 + 4, CAP);     host_wr(E2 + 8, B2);
        host_wr(E1, E3); host_wr(E1 + 4, CAP);     host_wr(E1 + 8, B1);
        host_wr(E3, E0); host_wr(E3 + 4, 32'h8);   host_wr(E3 + 8, B3);
        host_rd(E2 + 8, v);
        check(v == B2, "R2 host readback of buffer pointer", v, B2);
        @(negedge clk); ring_base = E0; ring_base_load = 1'b1;
        @(negedge clk); ring_base_load = 1'b0;
        pulse_enable();
    endtask

    task automatic t_basic_and_back_to_back();
        logic [31:0] v;
        // R3 R4: first frame goes to the loaded base entry
        send_frame("R4 bytes of 64-byte frame in entry 0x40", B0, 64, 1536, -1,
                   1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
        // R8: next frame in the very next cycle goes to the linked entry 0x60
        send_frame("R8 back-to-back 1-byte frame in linked entry", B2, 1, 1536, -1,
                   1'b0, 1'b1, 1'b0, '0, '0, 1'b1);
        host_rd(E0 + 4, v);
        check(v == 32'h8800_0040, "R5 R6 status of good 64-byte frame", v, 32'h8800_0040);
        host_rd(E2 + 4, v);
        check(v == 32'h8800_0001, "R5 status of 1-byte frame", v, 32'h8800_0001);
    endtask

    task automatic t_stray_err_gaps();
        logic [31:0] v;
        int bad = 0;
        // R11: beats without a first-beat flag while waiting
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (k == 2); rx_data = 8'hEE;
            #(CLK_P/4);
            if (buf_we !== 1'b0) bad++;
        end
        @(negedge clk); idle_rx();
        check(bad == 0, "R11 stray beats write nothing", 32'(bad), 32'd0);
        // R6 R11: error on beat 5, idle cycles between beats, entry 0x50
        send_frame("R11 gapped frame bytes in entry 0x50", B1, 20, 1536, 5,
                   1'b1, 1'b1, 1'b0, '0, '0, 1'b1);
        host_rd(E1 + 4, v);
        check(v == 32'h8000_0014, "R6 errored frame not marked good", v, 32'h8000_0014);
    endtask

    task automatic t_too_long_and_collisions();
        logic [31:0] v;
        // R7 R10: 12 bytes into capacity 8; host frees 0x40 in the eof cycle
        send_frame("R7 only capacity bytes written", B3, 12, 8, -1,
                   1'b0, 1'b1, 1'b1, E0 + 4, CAP, 1'b1);
        host_rd(E3 + 4, v);
        check(v == 32'h8040_0008, "R7 R6 too-long status", v, 32'h8040_0008);
        host_rd(E0 + 4, v);
        check(v == CAP, "R10 host write to other word lands", v, CAP);
        // R10: host writes the very status word being completed
        send_frame("R8 wrap to entry 0x40 bytes", B0, 30, 1536, -1,
                   1'b0, 1'b1, 1'b1, E0 + 4, 32'h0, 1'b1);
        host_rd(E0 + 4, v);
        check(v == 32'h8800_001E, "R10 engine value kept on same word", v, 32'h8800_001E);
        host_rd(E0 + 12, v);
        check(v == 32'hA5A5_0F0F, "R2 software word never written", v, 32'hA5A5_0F0F);
    endtask

    task automatic t_miss_and_resume();
        logic [31:0] v;
        // R9: entry 0x60 still owned by host
        send_frame("R9 dropped frame writes nothing", B2, 4, 0, -1,
                   1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
        #(CLK_P/4);
        check(missed_cnt == 16'd1, "R9 miss counted once", 32'(missed_cnt), 32'd1);
        host_rd(E2 + 4, v);
        check(v == 32'h8800_0001, "R9 owned entry unchanged", v, 32'h8800_0001);
        // R9: host returns the entry, but engine stays stopped
        host_wr(E2 + 4, CAP);
        send_frame("R9 frame while stopped not stored", B2, 4, 0, -1,
                   1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
        #(CLK_P/4);
        check(missed_cnt == 16'd1, "R9 frame while stopped not counted", 32'(missed_cnt), 32'd1);
        host_rd(E2 + 4, v);
        check(v == CAP, "R9 returned entry untouched while stopped", v, CAP);
        // R3 R9: enable restarts, pointer stayed at 0x60
        pulse_enable();
        send_frame("R3 frame after enable stored in entry 0x60", B2, 5, 1536, -1,
                   1'b0, 1'b1, 1'b0, '0, '0, 1'b1);
        host_rd(E2 + 4, v);
        check(v == 32'h8800_0005, "R9 resumed frame status", v, 32'h8800_0005);
    endtask

    initial begin
        t_reset();
        t_setup();
        t_basic_and_back_to_back();
        t_stray_err_gaps();
        t_too_long_and_collisions();
        t_miss_and_resume();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
        end
    end

endmodule